// File: doc/BRIEF.md
# Control Block Status and Command Logic

This block keeps the shared status word and the two unit states of a descriptor-driven network controller. The host writes a 16-bit command word. The word carries four acknowledge bits, a 3-bit field for the command unit and a 3-bit field for the receive unit. The block holds the word for one cycle, where it can be read back, and then acts on it and clears it.

Three sources report events. The command executor reports finished commands. The receive path reports received frames and loss of resources. The link status comes in as an input. From these the block keeps four interrupt causes and packs them with both unit states and the link byte into the status word. A level interrupt request stays high while any cause is pending.

Fetching and executing descriptors and all memory traffic belong to other blocks. This block only tracks state and reports it.

Top module: `ctl_block_status`

## Requirements
- R1: Reset is asynchronous and active low. It clears all causes, puts both units in idle (0), clears the held command word and loads the link byte with 0x80. The status word then reads 0x0080 and the interrupt output is low.
- R2: A written command word reads back on `cmd_readback` in the cycle after the write. It reads back as zero in the cycle after that, unless a new write arrives.
- R3: Bits 15:12 of the command word acknowledge the causes at status bits 15:12. Each set bit clears the matching cause. If the same cause is raised in the same cycle, the new event wins and the cause stays set.
- R4: The status word is built as follows:
  - causes in bits 15:12;
  - command-unit state shifted left by 8;
  - receive-unit state shifted left by 4;
  - the registered link byte ORed into bits 7:0.
- R5: The command-unit field is command bits 10:8. The codes act as follows:
  - 1 (start) and 6 (load-and-start) make the unit active (2).
  - 2 (resume) makes it active only from suspended (1).
  - 3 (suspend) makes it suspended.
  - 4 (abort) makes it idle and sets cause bit 13.
  - 0, 5 (load throttle) and 7 leave the state unchanged.
- R6: The receive-unit field is command bits 6:4. The codes act as follows:
  - 1 (start) makes the unit ready (4).
  - 2 (resume) makes it ready only from suspended (1).
  - 3 makes it suspended.
  - 4 makes it idle.
  - 0, 5, 6 and 7 are ignored.
- R7: A completion report without its complete flag (`rpt_c` low) has no effect on state, causes or interrupt.
- R8: A complete report with the OK flag set retires the command unit only when the unit is active and the list-end flag is set. Retiring means idle plus cause bit 13. Otherwise the state is unchanged.
- R9: A complete report with OK clear makes the command unit idle and sets cause bit 13, whatever the current state.
- R10: A complete report with its interrupt flag set raises cause bit 15 and so the interrupt output.
- R11: `irq` is high exactly while any of status bits 15:12 is set. It drops once all of them have been acknowledged.
- R12: A received-frame pulse sets cause bit 14. A stall report with a code of 2, 0xA or 0xC moves a ready receive unit to that code and sets cause bit 12. A stall report while the unit is not ready is ignored.
- R13: When a non-zero command-unit field and a complete report act in the same cycle, the command sets the command-unit state. The report's retire effect, including cause bit 13, is dropped, but its interrupt flag is still honoured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_we | input | 1 | Host write strobe for the command word |
| cmd_word | input | 16 | Command word: acknowledges 15:12, command-unit field 10:8, receive-unit field 6:4 |
| cmd_readback | output | 16 | Held command word, zero once processed |
| rpt_c | input | 1 | Completion report: command complete flag |
| rpt_ok | input | 1 | Completion report: command finished without error |
| rpt_irq | input | 1 | Completion report: command asked for an interrupt |
| rpt_list_end | input | 1 | Command list is exhausted |
| rx_frame | input | 1 | One-cycle pulse for a received frame |
| rx_stall | input | 1 | Receive path ran out of resources |
| rx_stall_code | input | 4 | Receive state to enter on a stall (2, 0xA or 0xC) |
| link_hi | input | 8 | Upper byte of the link status word |
| status_word | output | 16 | Packed status word |
| irq | output | 1 | Level interrupt request |

## Verification
Events on the report, receive and link inputs are sampled at one rising edge and show in `status_word` and `irq` right after it. A command word needs two edges: the first captures it, and the second applies it and clears the readback. Each bench step therefore writes the command one cycle before it drives the events, so both act on the same edge. That edge is also where the same-cycle priority cases arise. All outputs are compared at the falling edge after that processing edge, and never in the capture cycle.

// File: rtl/cbstat_pkg.sv
package cbstat_pkg;

  localparam int WORD_W     = 16;
  localparam int NIB_W      = 4;
  localparam int LINK_W     = 8;
  localparam int FLD_W      = 3;
  localparam int ACK_LSB    = 12;
  localparam int CU_FLD_LSB = 8;
  localparam int RU_FLD_LSB = 4;
  localparam int CU_SHIFT   = 8;
  localparam int RU_SHIFT   = 4;
  localparam int CAUSE_SHIFT = WORD_W - NIB_W;

  // cause nibble positions (status bits 15..12)
  localparam int CZ_DONE    = 3;
  localparam int CZ_FRAME   = 2;
  localparam int CZ_CU_LEFT = 1;
  localparam int CZ_RU_LEFT = 0;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [NIB_W-1:0]  nib_t;

  typedef enum logic [NIB_W-1:0] {
    CU_IDLE   = 4'h0,
    CU_SUSP   = 4'h1,
    CU_ACTIVE = 4'h2
  } cu_state_e;

  typedef enum logic [NIB_W-1:0] {
    RX_IDLE      = 4'h0,
    RX_SUSP      = 4'h1,
    RX_NORES     = 4'h2,
    RX_READY     = 4'h4,
    RX_NORES_BUF = 4'hA,
    RX_NOBUF     = 4'hC
  } rx_state_e;

  typedef enum logic [FLD_W-1:0] {
    CUC_NOP        = 3'd0,
    CUC_START      = 3'd1,
    CUC_RESUME     = 3'd2,
    CUC_SUSPEND    = 3'd3,
    CUC_ABORT      = 3'd4,
    CUC_LOAD_THR   = 3'd5,
    CUC_LOAD_START = 3'd6,
    CUC_RSVD       = 3'd7
  } cu_cmd_e;

  typedef enum logic [FLD_W-1:0] {
    RUC_NOP     = 3'd0,
    RUC_START   = 3'd1,
    RUC_RESUME  = 3'd2,
    RUC_SUSPEND = 3'd3,
    RUC_ABORT   = 3'd4,
    RUC_RSVD5   = 3'd5,
    RUC_RSVD6   = 3'd6,
    RUC_RSVD7   = 3'd7
  } ru_cmd_e;

  function automatic cu_state_e cu_cmd_next(input cu_state_e s, input cu_cmd_e c);
    case (c)
      CUC_START, CUC_LOAD_START: return CU_ACTIVE;
      CUC_RESUME:                return (s == CU_SUSP) ? CU_ACTIVE : s;
      CUC_SUSPEND:               return CU_SUSP;
      CUC_ABORT:                 return CU_IDLE;
      default:                   return s;
    endcase
  endfunction

  function automatic logic ru_cmd_acts(input ru_cmd_e c);
    return (c == RUC_START) || (c == RUC_RESUME) ||
           (c == RUC_SUSPEND) || (c == RUC_ABORT);
  endfunction

  function automatic rx_state_e ru_cmd_next(input rx_state_e s, input ru_cmd_e c);
    case (c)
      RUC_START:   return RX_READY;
      RUC_RESUME:  return (s == RX_SUSP) ? RX_READY : s;
      RUC_SUSPEND: return RX_SUSP;
      RUC_ABORT:   return RX_IDLE;
      default:     return s;
    endcase
  endfunction

  function automatic logic stall_code_ok(input nib_t code);
    return (code == RX_NORES) || (code == RX_NORES_BUF) || (code == RX_NOBUF);
  endfunction

  function automatic nib_t cause_next(input nib_t cur, input nib_t ack, input nib_t set);
    return (cur & ~ack) | set;
  endfunction

  function automatic word_t pack_status(input nib_t causes, input nib_t cu,
                                        input nib_t ru, input logic [LINK_W-1:0] link);
    word_t w;
    w = word_t'(causes) << CAUSE_SHIFT;
    w = w | (word_t'(cu) << CU_SHIFT);
    w = w | (word_t'(ru) << RU_SHIFT);
    w = w | word_t'(link);
    return w;
  endfunction

endpackage

// File: rtl/cbstat_cmd_port.sv
module cbstat_cmd_port
  import cbstat_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wr_en,
  input  word_t   wr_data,
  output word_t   held,
  output nib_t    ack,
  output cu_cmd_e cu_cmd,
  output ru_cmd_e ru_cmd
);

  word_t held_q;

  // a written word lives one cycle, then is consumed
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     held_q <= '0;
    else if (wr_en) held_q <= wr_data;
    else            held_q <= '0;
  end

  assign held   = held_q;
  assign ack    = held_q[ACK_LSB +: NIB_W];
  assign cu_cmd = cu_cmd_e'(held_q[CU_FLD_LSB +: FLD_W]);
  assign ru_cmd = ru_cmd_e'(held_q[RU_FLD_LSB +: FLD_W]);

  // R2
  readback_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> held_q == '0);

endmodule

// File: rtl/cbstat_cmd_unit.sv
module cbstat_cmd_unit
  import cbstat_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  cu_cmd_e   cu_cmd,
  input  logic      rpt_c,
  input  logic      rpt_ok,
  input  logic      rpt_irq,
  input  logic      rpt_list_end,
  output cu_state_e state,
  output logic      set_cu_left,
  output logic      set_done
);

  cu_state_e state_q, state_d;
  logic      host_owns;
  logic      rpt_take;
  logic      rpt_retire;

  assign host_owns  = (cu_cmd != CUC_NOP);
  assign rpt_take   = rpt_c;
  assign rpt_retire = rpt_take && (!rpt_ok || (rpt_list_end && state_q == CU_ACTIVE));

  always_comb begin
    state_d     = state_q;
    set_cu_left = 1'b0;
    if (host_owns) begin
      state_d     = cu_cmd_next(state_q, cu_cmd);
      set_cu_left = (cu_cmd == CUC_ABORT);
    end else if (rpt_retire) begin
      state_d     = CU_IDLE;
      set_cu_left = 1'b1;
    end
  end

  assign set_done = rpt_take && rpt_irq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= CU_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;

  // R5
  cu_abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cu_cmd == CUC_ABORT) |=> state_q == CU_IDLE);

  // R9
  cu_fail_retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rpt_c && !rpt_ok && cu_cmd == CUC_NOP) |=> state_q == CU_IDLE);

  // R7
  cu_no_c_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rpt_c && cu_cmd == CUC_NOP) |=> $stable(state_q));

endmodule

// File: rtl/cbstat_rx_unit.sv
module cbstat_rx_unit
  import cbstat_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  ru_cmd_e   ru_cmd,
  input  logic      rx_frame,
  input  logic      rx_stall,
  input  nib_t      rx_stall_code,
  output rx_state_e state,
  output logic      set_frame,
  output logic      set_ru_left
);

  rx_state_e state_q, state_d;
  logic      cmd_acts;
  logic      stall_hit;

  assign cmd_acts  = ru_cmd_acts(ru_cmd);
  assign stall_hit = rx_stall && (state_q == RX_READY) && stall_code_ok(rx_stall_code);

  always_comb begin
    state_d     = state_q;
    set_ru_left = 1'b0;
    if (cmd_acts) begin
      state_d = ru_cmd_next(state_q, ru_cmd);
    end else if (stall_hit) begin
      state_d     = rx_state_e'(rx_stall_code);
      set_ru_left = 1'b1;
    end
  end

  assign set_frame = rx_frame;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RX_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;

  // R6
  ru_start_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ru_cmd == RUC_START) |=> state_q == RX_READY);

  // R12
  ru_stall_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_stall && state_q != RX_READY && !cmd_acts) |=> $stable(state_q));

endmodule

// File: rtl/ctl_block_status.sv
module ctl_block_status
  import cbstat_pkg::*;
#(
  parameter logic [7:0] LINK_RST = 8'h80
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_we,
  input  logic [15:0] cmd_word,
  output logic [15:0] cmd_readback,
  input  logic        rpt_c,
  input  logic        rpt_ok,
  input  logic        rpt_irq,
  input  logic        rpt_list_end,
  input  logic        rx_frame,
  input  logic        rx_stall,
  input  logic [3:0]  rx_stall_code,
  input  logic [7:0]  link_hi,
  output logic [15:0] status_word,
  output logic        irq
);

  word_t       held;
  nib_t        ack;
  cu_cmd_e     cu_cmd;
  ru_cmd_e     ru_cmd;
  cu_state_e   cu_state;
  rx_state_e   ru_state;
  logic        set_cu_left, set_done, set_frame, set_ru_left;
  nib_t        cause_set;
  nib_t        cause_q;
  logic [LINK_W-1:0] link_q;

  cbstat_cmd_port u_port (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cmd_we),
    .wr_data (cmd_word),
    .held    (held),
    .ack     (ack),
    .cu_cmd  (cu_cmd),
    .ru_cmd  (ru_cmd)
  );

  cbstat_cmd_unit u_cu (
    .clk          (clk),
    .rst_n        (rst_n),
    .cu_cmd       (cu_cmd),
    .rpt_c        (rpt_c),
    .rpt_ok       (rpt_ok),
    .rpt_irq      (rpt_irq),
    .rpt_list_end (rpt_list_end),
    .state        (cu_state),
    .set_cu_left  (set_cu_left),
    .set_done     (set_done)
  );

  cbstat_rx_unit u_ru (
    .clk           (clk),
    .rst_n         (rst_n),
    .ru_cmd        (ru_cmd),
    .rx_frame      (rx_frame),
    .rx_stall      (rx_stall),
    .rx_stall_code (rx_stall_code),
    .state         (ru_state),
    .set_frame     (set_frame),
    .set_ru_left   (set_ru_left)
  );

  always_comb begin
    cause_set             = '0;
    cause_set[CZ_DONE]    = set_done;
    cause_set[CZ_FRAME]   = set_frame;
    cause_set[CZ_CU_LEFT] = set_cu_left;
    cause_set[CZ_RU_LEFT] = set_ru_left;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
      link_q  <= LINK_RST;
    end else begin
      cause_q <= cause_next(cause_q, ack, cause_set);
      link_q  <= link_hi;
    end
  end

  assign cmd_readback = held;
  assign status_word  = pack_status(cause_q, cu_state, ru_state, link_q);
  assign irq          = |cause_q;

  // R2
  readback_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we |=> cmd_readback == $past(cmd_word));

  // R3
  ack_frame_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack[CZ_FRAME] && !set_frame) |=> !status_word[ACK_LSB + CZ_FRAME]);

  // R3
  set_beats_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_done |=> status_word[ACK_LSB + CZ_DONE]);

  // R11
  irq_needs_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (|$past(cause_set)));

  // R11
  irq_drop_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> (|$past(ack)));

endmodule

// File: tb/ctl_block_status_bench.sv
module ctl_block_status_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int NV         = 30;

  typedef struct packed {
    logic [23:0] tag;
    logic [15:0] cmd;
    logic [7:0]  link;
    logic        rc, rok, rirq, rend;
    logic        frame, stall;
    logic [3:0]  scode;
    logic [15:0] exp_st;
    logic        exp_irq;
  } vec_t;

  // tag, cmd, link, rc, rok, rirq, rend, frame, stall, scode, expected status, expected irq
  localparam vec_t TBL [NV] = '{
    '{"R5",  16'h0100, 8'h80, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'h0, 16'h0280, 1'b0},
    '{"R6",  16'h0010, 8'h80, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'h0, 16'h02C0, 1'b0},
    '{"R10", 16'h0000, 8'h80, 1'b1,1'b1,1'b1,1'b0, 1'b0,1'b0, 4'h0, 16'h82C0, 1'b1},
    '{"R8",  16'h0000, 8'h80, 1'b1,1'b1,1'b0,1'b1, 1'b0,1'b0, 4'h0, 16'hA0C0, 1'b1},
    '{"R3",  16'h8000, 8'h80, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'h0, 16'h20C0, 1'b1},
    '{"R11", 16'h2000, 8'h80, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'h0, 16'h00C0, 1'b0},
    '{"R12", 16'h0000, 8'h80, 1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0, 4'h0, 16'h40C0, 1'b1},
    '{"R3",  16'h4000, 8'h80, 1'b0,1'b0,1'b0,1'b0, 1'b1,1'b0, 4'h0, 16'h40C0, 1'b1},
    '{"R3",  16'h4000, 8'h80, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'h0, 16'h00C0, 1'b0},
    '{"R12", 16'h0000, 8'h80, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1, 4'hC, 16'h10C0, 1'b1},
    '{"R12", 16'h0000, 8'h80, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b1, 4'h2, 16'h10C0, 1'b1},
    '{"R6",  16'h1010, 8'h80, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'h0, 16'h00C0, 1'b0},
    '{"R6",  16'h0030, 8'h80, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'h0, 16'h0090, 1'b0},
    '{"R6",  16'h0020, 8'h80, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'h0, 16'h00C0, 1'b0},
    '{"R6",  16'h0040, 8'h80, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'h0, 16'h0080, 1'b0},
    '{"R6",  16'h0050, 8'h80, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'h0, 16'h0080, 1'b0},
    '{"R5",  16'h0100, 8'h80, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'h0, 16'h0280, 1'b0},
    '{"R5",  16'h0300, 8'h80, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'h0, 16'h0180, 1'b0},
    '{"R5",  16'h0200, 8'h80, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'h0, 16'h0280, 1'b0},
    '{"R5",  16'h0500, 8'h80, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'h0, 16'h0280, 1'b0},
    '{"R7",  16'h0000, 8'h80, 1'b0,1'b1,1'b1,1'b1, 1'b0,1'b0, 4'h0, 16'h0280, 1'b0},
    '{"R9",  16'h0000, 8'h80, 1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'h0, 16'h2080, 1'b1},
    '{"R5",  16'h2600, 8'h80, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'h0, 16'h0280, 1'b0},
    '{"R5",  16'h0400, 8'h80, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'h0, 16'h2080, 1'b1},
    '{"R13", 16'h2100, 8'h80, 1'b1,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'h0, 16'h0280, 1'b0},
    '{"R8",  16'h0000, 8'h80, 1'b1,1'b1,1'b0,1'b1, 1'b0,1'b0, 4'h0, 16'h2080, 1'b1},
    '{"R8",  16'h2000, 8'h80, 1'b1,1'b1,1'b0,1'b1, 1'b0,1'b0, 4'h0, 16'h0080, 1'b0},
    '{"R5",  16'h0200, 8'h80, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'h0, 16'h0080, 1'b0},
    '{"R4",  16'h0700, 8'h00, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'h0, 16'h0000, 1'b0},
    '{"R4",  16'h0110, 8'h80, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0, 4'h0, 16'h02C0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_we = 1'b0;
  logic [15:0] cmd_word = '0;
  logic [15:0] cmd_readback;
  logic        rpt_c = 1'b0, rpt_ok = 1'b0, rpt_irq = 1'b0, rpt_list_end = 1'b0;
  logic        rx_frame = 1'b0, rx_stall = 1'b0;
  logic [3:0]  rx_stall_code = '0;
  logic [7:0]  link_hi = 8'h00;
  logic [15:0] status_word;
  logic        irq;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ctl_block_status u_ctl_block_status (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_we        (cmd_we),
    .cmd_word      (cmd_word),
    .cmd_readback  (cmd_readback),
    .rpt_c         (rpt_c),
    .rpt_ok        (rpt_ok),
    .rpt_irq       (rpt_irq),
    .rpt_list_end  (rpt_list_end),
    .rx_frame      (rx_frame),
    .rx_stall      (rx_stall),
    .rx_stall_code (rx_stall_code),
    .link_hi       (link_hi),
    .status_word   (status_word),
    .irq           (irq)
  );

  task automatic chk(input logic [23:0] tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  task automatic clear_events();
    rpt_c = 1'b0; rpt_ok = 1'b0; rpt_irq = 1'b0; rpt_list_end = 1'b0;
    rx_frame = 1'b0; rx_stall = 1'b0; rx_stall_code = '0;
  endtask

  // cycle 1: write command; cycle 2: events; both act on the same edge
  task automatic run_vec(input vec_t v);
    @(negedge clk);
    cmd_we = 1'b1; cmd_word = v.cmd; link_hi = v.link;
    @(negedge clk);
    cmd_we = 1'b0; cmd_word = '0;
    rpt_c = v.rc; rpt_ok = v.rok; rpt_irq = v.rirq; rpt_list_end = v.rend;
    rx_frame = v.frame; rx_stall = v.stall; rx_stall_code = v.scode;
    @(negedge clk);
    clear_events();
    chk(v.tag, "status", status_word, v.exp_st);
    chk(v.tag, "irq", {15'b0, irq}, {15'b0, v.exp_irq});
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset values, link input held low to expose the reset byte
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1", "status after reset", status_word, 16'h0080);
    chk("R1", "irq after reset", {15'b0, irq}, 16'h0000);
    chk("R1", "readback after reset", cmd_readback, 16'h0000);
    link_hi = 8'h80;

    // R2: held word visible for one cycle, then zero
    cmd_we = 1'b1; cmd_word = 16'hF0A5;
    @(negedge clk);
    cmd_we = 1'b0; cmd_word = '0;
    chk("R2", "readback held", cmd_readback, 16'hF0A5);
    @(negedge clk);
    chk("R2", "readback cleared", cmd_readback, 16'h0000);
    chk("R6", "resume from idle ignored", status_word, 16'h0080);

    for (int i = 0; i < NV; i++) run_vec(TBL[i]);

    // R1: reset in the middle of activity
    @(negedge clk);
    rx_frame = 1'b1; cmd_we = 1'b1; cmd_word = 16'h0300;
    @(negedge clk);
    rx_frame = 1'b0; cmd_we = 1'b0; cmd_word = '0;
    chk("R11", "irq raised by frame", {15'b0, irq}, 16'h0001);
    rst_n = 1'b0;
    #1;
    chk("R1", "status in reset", status_word, 16'h0080);
    chk("R1", "irq in reset", {15'b0, irq}, 16'h0000);
    chk("R1", "readback in reset", cmd_readback, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end

endmodule